// File: doc/BRIEF.md
# Tempo Clock Regenerator with Beat Resync

This block rebuilds a steady pulse train from a stream of incoming tempo strobes. A free-running reference counter measures the number of clock cycles between two consecutive strobes. That interval is scaled by a small rational factor (a 4-bit multiplier over a 4-bit divisor) and loaded as the reload value of an output pulse timer. The timer then emits one-cycle pulses at that spacing, without any further help from the input.

A tempo that is right on average still lets beats slide apart, so the block pulls the output timer back into phase with the input. Each incoming strobe that completes a group of 24 ticks (one quarter note) resets the timer phase, and the pulse follows in the next cycle. As an option, the block also resyncs on any strobe where the output timer is too far from its own pulse instant. If the input goes silent, the output keeps running at the last interval it measured and the tick grouping starts again.

Top module: `beat_clock_regen`

## Requirements
- R1: The measured period is the number of clock cycles from one sampled strobe to the next. The output interval is floor(period * mul / div), and it is forced to 1 when that result is 0.
- R2: A value of 0 on `mul_i` or on `div_i` acts as 1.
- R3: `pulse_o` stays low until two strobes have been seen. On the second strobe the interval is loaded and `pulse_o` is high in the cycle right after the one in which that strobe was high.
- R4: Once running, `pulse_o` is high for one cycle every interval cycles. A new measurement that triggers no resync changes only the spacing after the next pulse.
- R5: `beat_o` is high for exactly one cycle, the cycle after each strobe that completes a group of 24 strobes, counted from reset or from a timeout.
- R6: On a group-completing strobe the output timer restarts, so `pulse_o` is high in the next cycle whatever phase the timer was in.
- R7: When `drift_lim_i` is nonzero, a strobe forces the same restart if min(d, interval - d) exceeds `drift_lim_i`, where d is the number of cycles until the next pulse the timer would have given. A limit of 0 turns this check off.
- R8: If no strobe arrives in the 65535 cycles that follow the last one, measurement times out. Pulses continue at the last interval, the strobe group count returns to zero, and the next strobe only restarts measurement.
- R9: While reset is asserted and straight after it, `pulse_o` and `beat_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Incoming tempo strobe, one cycle per tick |
| mul_i | input | 4 | Interval multiplier (0 acts as 1) |
| div_i | input | 4 | Interval divisor (0 acts as 1) |
| drift_lim_i | input | 16 | Phase-error limit for drift resync; 0 disables it |
| pulse_o | output | 1 | Regenerated clock pulse |
| beat_o | output | 1 | One-cycle flag after every 24th strobe |

## Verification
On every cycle the assertions check the local timing rules. A beat flag lasts one cycle and only follows a strobe. No pulse appears before the timer is running. Every resync decision is followed by a pulse. A timeout empties the group count, and the timer never stops once it has started. Only the bench scenarios can show the arithmetic and the long-range behaviour: the scaled interval for a spread of periods and factors, including zero factors and the clamp to one; the phase restart on the 24th strobe with a timer that is out of step; the exact limit at which drift triggers a resync; and the way tempo and grouping behave after a gap longer than the timeout.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned FAC_W  = 4;
  localparam int unsigned CALC_W = 32;
  typedef logic [CALC_W-1:0] calc_t;

  // zero factor behaves as one
  function automatic calc_t fac_eff(input logic [FAC_W-1:0] f);
    return (f == '0) ? calc_t'(1) : calc_t'(f);
  endfunction

  // scaled output interval, never below one cycle
  function automatic calc_t scale_interval(input calc_t per,
                                           input logic [FAC_W-1:0] mul,
                                           input logic [FAC_W-1:0] div);
    calc_t q;
    q = (per * fac_eff(mul)) / fac_eff(div);
    if (q == '0) q = calc_t'(1);
    return q;
  endfunction

  // distance to the nearest output pulse instant
  function automatic calc_t phase_error(input calc_t remain, input calc_t rel);
    calc_t back;
    back = rel - remain;
    return (remain < back) ? remain : back;
  endfunction
endpackage

// File: rtl/bcr_period_meter.sv
module bcr_period_meter #(
  parameter int unsigned TIMEOUT = 65535,
  parameter int unsigned PPQ     = 24,
  parameter int unsigned PER_W   = 16,
  parameter int unsigned GRP_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic             meas_vld_o,
  output logic [PER_W-1:0] meas_per_o,
  output logic             grp_end_o,
  output logic [GRP_W-1:0] grp_cnt_o,
  output logic             timeout_o,
  output logic             beat_o
);
  localparam logic [PER_W-1:0] TMO_V  = PER_W'(TIMEOUT);
  localparam logic [GRP_W-1:0] LAST_G = GRP_W'(PPQ - 1);

  logic [PER_W-1:0] ref_cnt;
  logic             have_ref;

  assign meas_vld_o = tick_i && have_ref;
  assign meas_per_o = ref_cnt;
  assign grp_end_o  = tick_i && (grp_cnt_o == LAST_G);
  assign timeout_o  = have_ref && !tick_i && (ref_cnt == TMO_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt   <= '0;
      have_ref  <= 1'b0;
      grp_cnt_o <= '0;
      beat_o    <= 1'b0;
    end else begin
      beat_o <= grp_end_o;
      if (tick_i) begin
        ref_cnt   <= PER_W'(1);
        have_ref  <= 1'b1;
        grp_cnt_o <= grp_end_o ? '0 : grp_cnt_o + GRP_W'(1);
      end else if (timeout_o) begin
        have_ref  <= 1'b0;
        grp_cnt_o <= '0;
      end else if (ref_cnt != TMO_V) begin
        ref_cnt <= ref_cnt + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/bcr_pulse_timer.sv
module bcr_pulse_timer #(
  parameter int unsigned OUT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_vld_i,
  input  logic [OUT_W-1:0] upd_rel_i,
  input  logic             force_i,
  output logic             pulse_o,
  output logic             running_o,
  output logic [OUT_W-1:0] remain_o,
  output logic [OUT_W-1:0] reload_o
);
  logic [OUT_W-1:0] nxt_rel;
  assign nxt_rel = upd_vld_i ? upd_rel_i : reload_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o   <= 1'b0;
      running_o <= 1'b0;
      remain_o  <= '0;
      reload_o  <= OUT_W'(1);
    end else if (force_i) begin
      reload_o  <= upd_rel_i;
      remain_o  <= upd_rel_i - OUT_W'(1);
      pulse_o   <= 1'b1;
      running_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
      if (upd_vld_i) reload_o <= upd_rel_i;
      if (running_o) begin
        if (remain_o == '0) begin
          remain_o <= nxt_rel - OUT_W'(1);
          pulse_o  <= 1'b1;
        end else begin
          remain_o <= remain_o - OUT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/beat_clock_regen.sv
module beat_clock_regen
  import bcr_pkg::*;
#(
  parameter int unsigned TIMEOUT = 65535,
  parameter int unsigned PPQ     = 24,
  parameter int unsigned LIM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [3:0]       mul_i,
  input  logic [3:0]       div_i,
  input  logic [LIM_W-1:0] drift_lim_i,
  output logic             pulse_o,
  output logic             beat_o
);
  localparam int unsigned PER_W = $clog2(TIMEOUT + 1);
  localparam int unsigned GRP_W = $clog2(PPQ);
  localparam int unsigned OUT_W = PER_W + FAC_W;

  logic             meas_vld_w;
  logic [PER_W-1:0] meas_per_w;
  logic             grp_end_w;
  logic [GRP_W-1:0] grp_cnt_w;
  logic             timeout_w;
  logic             running_w;
  logic [OUT_W-1:0] remain_w;
  logic [OUT_W-1:0] reload_w;
  logic [OUT_W-1:0] scaled_w;
  logic             drift_hit_w;
  logic             resync_w;

  bcr_period_meter #(
    .TIMEOUT(TIMEOUT), .PPQ(PPQ), .PER_W(PER_W), .GRP_W(GRP_W)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .meas_vld_o(meas_vld_w), .meas_per_o(meas_per_w),
    .grp_end_o(grp_end_w), .grp_cnt_o(grp_cnt_w),
    .timeout_o(timeout_w), .beat_o(beat_o)
  );

  assign scaled_w    = OUT_W'(scale_interval(calc_t'(meas_per_w), mul_i, div_i));
  assign drift_hit_w = running_w && (drift_lim_i != '0) &&
                       (phase_error(calc_t'(remain_w), calc_t'(reload_w)) > calc_t'(drift_lim_i));
  assign resync_w    = meas_vld_w && (!running_w || grp_end_w || drift_hit_w);

  bcr_pulse_timer #(.OUT_W(OUT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .upd_vld_i(meas_vld_w), .upd_rel_i(scaled_w), .force_i(resync_w),
    .pulse_o(pulse_o), .running_o(running_w),
    .remain_o(remain_w), .reload_o(reload_w)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int unsigned GRP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             pulse_o,
  input logic             beat_o,
  input logic             running,
  input logic             resync,
  input logic             timeout_evt,
  input logic [GRP_W-1:0] grp_cnt
);
  // R5
  beat_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |-> $past(tick_i));
  // R5
  beat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |=> !beat_o);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pulse_o);
  // R6
  resync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> pulse_o);
  // R8
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (grp_cnt == '0));
  // R8
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

bind beat_clock_regen bcr_checker #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pulse_o(pulse_o),
  .beat_o(beat_o), .running(running_w), .resync(resync_w),
  .timeout_evt(timeout_w), .grp_cnt(grp_cnt_w)
);

// File: tb/tb_beat_clock_regen.sv
module tb_beat_clock_regen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [3:0]  mul_i = 4'd1;
  logic [3:0]  div_i = 4'd1;
  logic [15:0] drift_lim_i = 16'd0;
  logic        pulse_o;
  logic        beat_o;

  beat_clock_regen dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mul_i(mul_i), .div_i(div_i),
    .drift_lim_i(drift_lim_i), .pulse_o(pulse_o), .beat_o(beat_o)
  );

  always #5 clk = ~clk;

  int cyc = 0, npulse = 0, nbeat = 0, last_p = 0, prev_p = 0;
  int nchk = 0, nerr = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pulse_o) begin
      prev_p <= last_p;
      last_p <= cyc;
      npulse <= npulse + 1;
    end
    if (beat_o) nbeat <= nbeat + 1;
  end

  // {period, mul, div, expected interval}
  localparam logic [31:0] VEC [7] = '{
    {8'd10, 4'd1,  4'd1,  16'd10},
    {8'd10, 4'd0,  4'd0,  16'd10},
    {8'd12, 4'd3,  4'd4,  16'd9},
    {8'd7,  4'd15, 4'd1,  16'd105},
    {8'd9,  4'd1,  4'd15, 16'd1},
    {8'd20, 4'd2,  4'd1,  16'd40},
    {8'd25, 4'd0,  4'd3,  16'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    int base;
    @(negedge clk);
    @(negedge clk);
    check("R9 pulse in reset", int'(pulse_o), 0);
    check("R9 beat in reset", int'(beat_o), 0);
    do_reset();
    check("R9 pulse after reset", int'(pulse_o), 0);

    // R3: a single strobe leaves the output idle
    do_tick();
    repeat (60) @(negedge clk);
    check("R3 idle after one strobe", npulse, 0);

    // R1 R2 R3 R4: table of period / factor / interval
    for (int i = 0; i < 7; i++) begin
      int per, expv;
      per   = int'(VEC[i][31:24]);
      mul_i = VEC[i][23:20];
      div_i = VEC[i][19:16];
      expv  = int'(VEC[i][15:0]);
      drift_lim_i = 16'd0;
      do_reset();
      do_tick();
      repeat (per - 1) @(negedge clk);
      do_tick();
      check("R3 first pulse on second strobe", int'(pulse_o), 1);
      repeat (expv + 3) @(negedge clk);
      check("R1 R2 R4 interval", last_p - prev_p, expv);
    end

    // R5 R6: interval 30 from strobes every 10, out of step at strobe 24
    mul_i = 4'd3; div_i = 4'd1; drift_lim_i = 16'd0;
    do_reset();
    base = nbeat;
    for (int k = 1; k <= 24; k++) begin
      do_tick();
      if (k == 3)  check("R7 no drift resync with limit 0", int'(pulse_o), 0);
      if (k == 23) check("R5 no beat before 24th", int'(beat_o), 0);
      if (k == 24) begin
        check("R5 beat after 24th", int'(beat_o), 1);
        check("R6 resync pulse on 24th", int'(pulse_o), 1);
      end
      repeat (9) @(negedge clk);
    end
    check("R5 single beat per group", nbeat - base, 1);

    // R7: phase error 10 at third strobe
    drift_lim_i = 16'd9;
    do_reset();
    for (int k = 1; k <= 3; k++) begin
      do_tick();
      if (k == 3) check("R7 resync when error above limit", int'(pulse_o), 1);
      repeat (9) @(negedge clk);
    end
    drift_lim_i = 16'd10;
    do_reset();
    for (int k = 1; k <= 3; k++) begin
      do_tick();
      if (k == 3) check("R7 no resync at limit", int'(pulse_o), 0);
      repeat (9) @(negedge clk);
    end

    // R8: timeout holds tempo and clears grouping
    mul_i = 4'd1; div_i = 4'd1; drift_lim_i = 16'd0;
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      do_tick();
      repeat (11) @(negedge clk);
    end
    base = npulse;
    repeat (65600) @(negedge clk);
    check("R8 interval held after timeout", last_p - prev_p, 12);
    check("R8 pulses continue", int'((npulse - base) > 5000), 1);
    for (int k = 1; k <= 24; k++) begin
      do_tick();
      if (k == 19) check("R8 group restarted", int'(beat_o), 0);
      if (k == 24) check("R8 beat after 24 new strobes", int'(beat_o), 1);
      repeat (11) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule